// File: doc/BRIEF.md
# Status Register and Write Protection Unit

This block sits behind the serial front end of a small serial non-volatile memory. It holds the status byte and rules on every request that would change stored data. The front end sends a one-cycle commit pulse for each finished command. These commands are write-enable set, write-enable clear, status write with its data byte, and array write with a start address and a byte count. The block also watches the level of the write-protect pin (active low). From these inputs it keeps a write-enable latch, a busy flag, two block-protect bits and a sticky status-lock bit. It runs the self-timed programming cycle. It blocks array writes whose page lies in the protected upper part of the array.

A controller with three states does the work. `ST_IDLE` accepts commands. `ST_SR_CYC` times a status write. `ST_ARR_CYC` times an array write. `ST_IDLE` goes to `ST_SR_CYC` on an accepted status write and to `ST_ARR_CYC` on an accepted array write. Both busy states return to `ST_IDLE` when the cycle timer reports the last cycle. A status write stores its new lock and protect bits in a pending register, and these bits replace the live copy only on that final cycle. The lock and protect bits are the non-volatile part. Reset leaves them alone, and they start from a parameter value.

Top module: `sreg_wprot`

## Requirements
- R1: Reset clears the write-enable latch and the busy flag, so `status_o` reads 0x00 from the defaults. The lock bit and the protect bits keep the values they had before reset, and this holds even when reset cuts a status write short.
- R2: `status_o` is {lock (bit 7), 0, 0, 0, protect[1] (bit 3), protect[0] (bit 2), write-enable latch (bit 1), busy (bit 0)}. A status write takes only data bits 7, 3 and 2. Data bits 6, 5, 4, 1 and 0 have no effect.
- R3: A write-enable set pulse makes bit 1 read 1 after the next clock edge. A write-enable clear pulse makes it read 0.
- R4: A status write or an array write that arrives while the write-enable latch is 0 is refused. No cycle starts and `arr_go_o` stays low.
- R5: An accepted write sets busy from the edge that accepts it, for exactly `CYC_LEN` clock cycles. At the end, busy and the write-enable latch both return to 0.
- R6: During a status-write cycle, `status_o` bits 7, 3 and 2 still show the old values. The new values appear on the same edge that clears busy.
- R7: The protected region depends on the protect bits. 00 protects nothing. 01 protects addresses at or above 3/4 of `DEPTH` (0x1800 for 8192 bytes). 10 protects addresses at or above half of `DEPTH` (0x1000). 11 protects the whole array.
- R8: An array write whose start address is protected is dropped. `arr_go_o` stays low, busy stays 0 and the write-enable latch keeps its value of 1.
- R9: When the lock bit is 1 and `wp_n` is low, status writes are refused even with the write-enable latch at 1. This happens whichever of the two conditions came first. Driving `wp_n` high makes status writes possible again.
- R10: While busy is 1, all four command pulses are ignored.
- R11: An accepted array write raises `arr_go_o` for the one cycle after the accepting edge. An array write with a byte count of 0 is refused.
- R12: When several command pulses arrive in one cycle, only one of them acts. Clear beats set, set beats status write, and status write beats array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect pin level, low = protect |
| wren_i | input | 1 | Commit pulse: set write-enable latch |
| wrdi_i | input | 1 | Commit pulse: clear write-enable latch |
| wrsr_i | input | 1 | Commit pulse: status write |
| wrsr_data | input | 8 | Data byte of the status write |
| wr_i | input | 1 | Commit pulse: array write |
| wr_addr | input | ADDR_W (13) | Start address of the array write |
| wr_len | input | LEN_W (6) | Byte count of the array write |
| status_o | output | 8 | Status byte |
| arr_go_o | output | 1 | One-cycle grant for the array programmer |

## Verification
The bench builds the block with `DEPTH` = 8192 and `PAGE` = 32, and with `CYC_LEN` cut to 12 cycles so that every timed cycle can be counted edge by edge. At that depth the bench can probe the quarter and half boundaries just below and at 0x1800 and 0x1000, as well as addresses at both ends of the array. `NV_INIT` stays at zero, which gives a known starting byte, and the retained bits are then driven to non-zero values before a reset.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SR_CYC  = 2'd1,
        ST_ARR_CYC = 2'd2
    } wstate_e;

    typedef enum logic [2:0] {
        C_NONE = 3'd0,
        C_WRDI = 3'd1,
        C_WREN = 3'd2,
        C_WRSR = 3'd3,
        C_WR   = 3'd4
    } wcmd_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] bp;
    } nv_bits_t;

endpackage

// File: rtl/sreg_cycle_timer.sv
module sreg_cycle_timer #(
    parameter int LEN = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: the count never passes the last cycle of the window
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5: an idle timer sits at zero one edge later
    assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/sreg_region_guard.sv
module sreg_region_guard #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    logic top_half;
    logic top_quarter;

    assign top_half    = addr[ADDR_W-1];
    assign top_quarter = addr[ADDR_W-1] & addr[ADDR_W-2];

    always_comb begin
        unique case (bp)
            2'b00:   prot = 1'b0;
            2'b01:   prot = top_quarter;
            2'b10:   prot = top_half;
            default: prot = 1'b1;
        endcase
    end

endmodule

// File: rtl/sreg_wprot.sv
module sreg_wprot
    import sreg_pkg::*;
#(
    parameter int       DEPTH   = 8192,
    parameter int       PAGE    = 32,
    parameter int       CYC_LEN = 500000,
    parameter bit [2:0] NV_INIT = 3'b000,
    localparam int      ADDR_W  = $clog2(DEPTH),
    localparam int      LEN_W   = $clog2(PAGE) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [7:0]        wrsr_data,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    output logic [7:0]        status_o,
    output logic              arr_go_o
);
    wstate_e  st_q, st_d;
    wcmd_e    cmd;
    nv_bits_t nv_q = nv_bits_t'(NV_INIT);
    nv_bits_t nv_pend_q;
    logic     wel_q;
    logic     go_q;
    logic     wip;
    logic     cyc_done;
    logic     addr_prot;
    logic     hw_lock;
    logic     sr_ok;
    logic     wr_ok;

    assign wip     = (st_q != ST_IDLE);
    assign hw_lock = nv_q.lock & ~wp_n;

    sreg_cycle_timer #(.LEN(CYC_LEN)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (wip),
        .done (cyc_done)
    );

    sreg_region_guard #(.ADDR_W(ADDR_W)) u_guard (
        .bp  (nv_q.bp),
        .addr(wr_addr),
        .prot(addr_prot)
    );

    // one command per cycle, nothing while a cycle runs
    always_comb begin
        if (wip)         cmd = C_NONE;
        else if (wrdi_i) cmd = C_WRDI;
        else if (wren_i) cmd = C_WREN;
        else if (wrsr_i) cmd = C_WRSR;
        else if (wr_i)   cmd = C_WR;
        else             cmd = C_NONE;
    end

    assign sr_ok = (cmd == C_WRSR) && wel_q && !hw_lock;
    assign wr_ok = (cmd == C_WR) && wel_q && !addr_prot && (wr_len != '0);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (sr_ok)      st_d = ST_SR_CYC;
                else if (wr_ok) st_d = ST_ARR_CYC;
            end
            ST_SR_CYC:  if (cyc_done) st_d = ST_IDLE;
            ST_ARR_CYC: if (cyc_done) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q     <= 1'b0;
            go_q      <= 1'b0;
            nv_pend_q <= '0;
        end else begin
            go_q <= wr_ok;
            if (cmd == C_WREN) wel_q <= 1'b1;
            if (cmd == C_WRDI) wel_q <= 1'b0;
            if (wip && cyc_done) wel_q <= 1'b0;
            if (sr_ok) nv_pend_q <= '{lock: wrsr_data[7], bp: wrsr_data[3:2]};
        end
    end

    // retained bits: no reset, new value only when a status cycle ends
    always_ff @(posedge clk) begin
        if (rst_n && st_q == ST_SR_CYC && cyc_done) nv_q <= nv_pend_q;
    end

    assign status_o = {nv_q.lock, 3'b000, nv_q.bp, wel_q, wip};
    assign arr_go_o = go_q;

    // R4: a cycle only starts if the latch was set when it was accepted
    assert_start_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel_q));

    // R5: the latch is down whenever a cycle has just ended
    assert_end_clears_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel_q);

    // R6: retained bits move only on the closing edge of a status cycle
    assert_nv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q == ST_SR_CYC && cyc_done) |=> $stable(nv_q));

    // R8: a grant never follows a protected start address
    assert_go_unprot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_go_o |-> $past(!addr_prot));

    // R9: a status cycle never starts under the pin lock
    assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SR_CYC && $past(st_q) == ST_IDLE) |-> $past(!(nv_q.lock && !wp_n)));

    // R10: the latch holds still inside a running cycle
    assert_busy_wel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && !cyc_done) |=> $stable(wel_q));

endmodule

// File: tb/test_sreg_wprot.sv
module test_sreg_wprot;
    localparam int DEPTH = 8192;
    localparam int PAGE  = 32;
    localparam int CYC   = 12;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = $clog2(PAGE) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic          wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0, wr_i = 1'b0;
    logic [7:0]    wrsr_data = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [LW-1:0] wr_len = '0;
    logic [7:0]    status_o;
    logic          arr_go_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sreg_wprot #(.DEPTH(DEPTH), .PAGE(PAGE), .CYC_LEN(CYC), .NV_INIT(3'b000)) i_sreg_wprot (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i), .wrsr_data(wrsr_data),
        .wr_i(wr_i), .wr_addr(wr_addr), .wr_len(wr_len),
        .status_o(status_o), .arr_go_o(arr_go_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic p_wren();
        @(negedge clk); wren_i = 1'b1; @(negedge clk); wren_i = 1'b0;
    endtask

    task automatic p_wrdi();
        @(negedge clk); wrdi_i = 1'b1; @(negedge clk); wrdi_i = 1'b0;
    endtask

    task automatic p_wrsr(input logic [7:0] d);
        @(negedge clk); wrsr_i = 1'b1; wrsr_data = d;
        @(negedge clk); wrsr_i = 1'b0;
    endtask

    task automatic p_wr(input int a, input int n, output logic go);
        @(negedge clk); wr_i = 1'b1; wr_addr = AW'(a); wr_len = LW'(n);
        @(negedge clk); wr_i = 1'b0; go = arr_go_o;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (status_o[0] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_status(input logic [7:0] d);
        int n;
        p_wren();
        p_wrsr(d);
        busy_len(n);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset status", status_o, 8'h00);
        check("R1 reset go", arr_go_o, 0);
    endtask

    task automatic t_latch();
        p_wren();
        check("R3 set latch", status_o, 8'h02);
        p_wrdi();
        check("R3 clear latch", status_o, 8'h00);
    endtask

    task automatic t_no_latch();
        logic go;
        p_wrsr(8'h8C);
        check("R4 status write refused", status_o, 8'h00);
        p_wr(16, 4, go);
        check("R4 array write no grant", go, 0);
        check("R4 array write no busy", status_o, 8'h00);
    endtask

    task automatic t_status_cycle();
        int n;
        p_wren();
        p_wrsr(8'hFF);
        check("R6 old bits while busy", status_o, 8'h03);
        busy_len(n);
        check("R5 busy length", n, CYC);
        check("R2 R5 status after cycle", status_o, 8'h8C);
        set_status(8'h00);
        check("R2 cleared back", status_o, 8'h00);
    endtask

    task automatic t_busy_ignore();
        logic go;
        int n;
        p_wren();
        p_wr(100, 8, go);
        check("R11 grant pulse", go, 1);
        @(negedge clk);
        check("R11 grant lasts one cycle", arr_go_o, 0);
        p_wrdi();
        check("R10 clear ignored while busy", status_o[1], 1);
        p_wrsr(8'h8C);
        p_wr(200, 1, go);
        check("R10 write ignored while busy", go, 0);
        busy_len(n);
        check("R10 status write ignored", status_o, 8'h00);
        p_wren();
        p_wr(50, 0, go);
        check("R11 zero count refused", go, 0);
        check("R11 zero count no busy", status_o, 8'h02);
        p_wrdi();
    endtask

    task automatic t_regions();
        logic go;
        int n;
        set_status(8'h04);
        check("R7 quarter set", status_o, 8'h04);
        p_wren(); p_wr(16'h17FF, 1, go);
        check("R7 below quarter granted", go, 1);
        busy_len(n);
        check("R5 latch clear after array cycle", status_o, 8'h04);
        p_wren(); p_wr(16'h1800, 1, go);
        check("R8 quarter dropped", go, 0);
        check("R8 latch kept, no busy", status_o, 8'h06);
        p_wrdi();
        set_status(8'h08);
        p_wren(); p_wr(16'h0FFF, 2, go);
        check("R7 below half granted", go, 1);
        busy_len(n);
        p_wren(); p_wr(16'h1000, 2, go);
        check("R7 R8 half dropped", go, 0);
        p_wrdi();
        set_status(8'h0C);
        p_wren(); p_wr(0, 1, go);
        check("R7 whole array dropped", go, 0);
        p_wrdi();
        set_status(8'h00);
        p_wren(); p_wr(16'h1FFF, 1, go);
        check("R7 none protected top granted", go, 1);
        busy_len(n);
    endtask

    task automatic t_hw_lock();
        set_status(8'h80);
        wp_n = 1'b0;
        p_wren(); p_wrsr(8'h00);
        check("R9 locked after pin low", status_o, 8'h82);
        wp_n = 1'b1;
        p_wrsr(8'h00);
        check("R9 pin high accepts", status_o[0], 1);
        begin int n; busy_len(n); end
        check("R9 unlocked write done", status_o, 8'h00);
        wp_n = 1'b0;
        set_status(8'h84);
        check("R9 lock bit set with pin low", status_o, 8'h84);
        p_wren(); p_wrsr(8'h00);
        check("R9 locked after bit set", status_o, 8'h86);
        p_wrdi();
        wp_n = 1'b1;
        set_status(8'h00);
        check("R9 released", status_o, 8'h00);
    endtask

    task automatic t_priority();
        p_wren();
        @(negedge clk); wren_i = 1'b1; wrdi_i = 1'b1;
        @(negedge clk); wren_i = 1'b0; wrdi_i = 1'b0;
        check("R12 clear beats set", status_o, 8'h00);
        p_wren();
        @(negedge clk); wren_i = 1'b1; wrsr_i = 1'b1; wrsr_data = 8'h8C;
        @(negedge clk); wren_i = 1'b0; wrsr_i = 1'b0;
        check("R12 set beats status write", status_o, 8'h02);
        p_wrdi();
    endtask

    task automatic t_retain();
        set_status(8'h08);
        p_wren();
        do_reset();
        check("R1 protect bits kept", status_o, 8'h08);
        p_wren(); p_wrsr(8'h84);
        do_reset();
        check("R1 cut cycle keeps old bits", status_o, 8'h08);
    endtask

    initial begin
        t_reset();
        t_latch();
        t_no_latch();
        t_status_cycle();
        t_busy_ignore();
        t_regions();
        t_hw_lock();
        t_priority();
        t_retain();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule